// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate and Decoder

This block sits between a processor's memory chip-enable and up to four low-power static memories. While the supply is healthy, it steers the single active-low enable to one of four active-low outputs, selected by a two-bit code. When a digital power-fail flag rises, it stops new accesses from reaching the memories, so their contents are write protected. An access that was already running when the flag rose may finish, but only up to a bounded timeout. After the flag clears, every output stays inactive for a recovery period, which gives the processor time to settle before memory traffic resumes.

The two durations are parameters counted in clock cycles. All outputs are registered, so every output reflects the inputs sampled on the previous rising clock edge. Reset behaves as if power had just returned: the block begins in the recovery hold.

Top module: `pf_ce_gate`

## Requirements
- R1: In normal operation with `ce_n` low, the registered output `en_n[i]` goes low one cycle later, where i = {`sel_b`,`sel_a`}. The codes map as 00 to bit 0, 01 to bit 1, 10 to bit 2 and 11 to bit 3.
- R2: When `ce_n` is sampled high, all four bits of `en_n` are high on the next cycle, whatever the select bits are.
- R3: At most one bit of `en_n` is ever low.
- R4: When `pwr_fail` is sampled high and no access is in flight (`ce_n` high), `en_n` is all high and `wp` is high from the next cycle on.
- R5: When `pwr_fail` is first sampled high while `ce_n` is low, the access continues on the select code latched at that edge, even if the select bits change. Once `ce_n` is sampled high, the outputs are forced inactive.
- R6: An access that continues after power fail is cut off after WPT_CYC cycles. With detection at edge D, the enable stays active after edges D to D+WPT_CYC-1 and is forced high after edge D+WPT_CYC.
- R7: A new access that starts while `pwr_fail` is high and the outputs are forced is never passed to `en_n`.
- R8: From the first edge at which `pwr_fail` is sampled low after being high, the outputs stay forced for REC_CYC cycles, and decoding resumes at the next edge. This also holds when the flag clears during a continuing access. If the flag rises again during the hold, the full hold restarts once it clears.
- R9: Synchronous reset sets `en_n` to all ones and `wp` high. After release, the outputs stay forced through the first REC_CYC-1 edges, and decoding resumes at edge REC_CYC.
- R10: `wp` is high exactly when the outputs are forced inactive by power fail, timeout or recovery hold. It is low during normal decoding and during a continuing access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low memory chip enable from the processor |
| sel_a | input | 1 | Select bit, low-order |
| sel_b | input | 1 | Select bit, high-order |
| pwr_fail | input | 1 | Supply below threshold, synchronous to clk |
| en_n | output | 4 | Conditioned active-low enables, one per memory |
| wp | output | 1 | High while the outputs are forced inactive |

## Verification
The critical coincidence is a power-fail detection that lands in the same cycle as a live access. The bench raises `pwr_fail` on the very edge where `ce_n` is still low. It then checks that the enable is held rather than dropped, and that a select change afterwards does not move it. Two further collisions are also provoked: the flag clearing while that access is still running, and the flag rising again partway through the recovery hold. For each, the bench judges edge by edge whether the outputs are forced and whether the hold restarts its full length.

// File: rtl/pf_ce_pkg.sv
package pf_ce_pkg;
  localparam int SEL_W  = 2;
  localparam int NUM_EN = 1 << SEL_W;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,  // recovery hold after power return or reset
    ST_RUN   = 2'd1,  // normal decoding
    ST_DRAIN = 2'd2,  // access in flight allowed to finish
    ST_PROT  = 2'd3   // protected while power fail persists
  } gate_st_t;
endpackage

// File: rtl/pf_ce_timer.sv
module pf_ce_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pf_ce_seq.sv
module pf_ce_seq
  import pf_ce_pkg::*;
#(
  parameter int WPT_CYC = 4,
  parameter int REC_CYC = 8,
  parameter int CW      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             pwr_fail,
  output logic             pass,
  output logic [SEL_W-1:0] sel_eff
);
  localparam logic [CW-1:0] WPT_LAST = CW'(WPT_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

  gate_st_t         state_q, state_d;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt;
  logic             clr;

  pf_ce_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .cnt (cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD: begin
        if (pwr_fail)             state_d = ST_PROT;
        else if (cnt == REC_LAST) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (pwr_fail) state_d = ce_n ? ST_PROT : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!pwr_fail)            state_d = ST_HOLD;
        else if (ce_n)            state_d = ST_PROT;
        else if (cnt == WPT_LAST) state_d = ST_PROT;
      end
      default: begin
        if (!pwr_fail) state_d = ST_HOLD;
      end
    endcase
  end

  assign clr     = (state_d != state_q);
  assign pass    = (state_d == ST_RUN) || (state_d == ST_DRAIN);
  assign sel_eff = (state_q == ST_DRAIN) ? sel_q : sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HOLD;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN) sel_q <= sel;
    end
  end
endmodule

// File: rtl/pf_ce_dec.sv
module pf_ce_dec
  import pf_ce_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pass,
  input  logic              ce_n,
  input  logic [SEL_W-1:0]  sel_eff,
  output logic [NUM_EN-1:0] en_n,
  output logic              wp
);
  logic [NUM_EN-1:0] en_d;

  for (genvar i = 0; i < NUM_EN; i++) begin : g_lane
    assign en_d[i] = ~(pass & ~ce_n & (sel_eff == SEL_W'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_n <= '1;
      wp   <= 1'b1;
    end else begin
      en_n <= en_d;
      wp   <= ~pass;
    end
  end
endmodule

// File: rtl/pf_ce_gate.sv
module pf_ce_gate
  import pf_ce_pkg::*;
#(
  parameter int WPT_CYC = 1250,
  parameter int REC_CYC = 15000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       sel_a,
  input  logic       sel_b,
  input  logic       pwr_fail,
  output logic [3:0] en_n,
  output logic       wp
);
  localparam int MAX_CYC = (WPT_CYC > REC_CYC) ? WPT_CYC : REC_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic             pass;
  logic [SEL_W-1:0] sel_eff;

  pf_ce_seq #(
    .WPT_CYC (WPT_CYC),
    .REC_CYC (REC_CYC),
    .CW      (CW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .sel      ({sel_b, sel_a}),
    .pwr_fail (pwr_fail),
    .pass     (pass),
    .sel_eff  (sel_eff)
  );

  pf_ce_dec u_dec (
    .clk     (clk),
    .rst     (rst),
    .pass    (pass),
    .ce_n    (ce_n),
    .sel_eff (sel_eff),
    .en_n    (en_n),
    .wp      (wp)
  );
endmodule

// File: rtl/pf_ce_gate_chk.sv
module pf_ce_gate_chk #(
  parameter int WPT_CYC = 4,
  parameter int REC_CYC = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       pwr_fail,
  input logic [3:0] en_n,
  input logic       wp
);
  int tmo_q;   // consecutive cycles with power fail and an active enable
  int hold_q;  // cycles since power fail was last sampled high (1 after reset)

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q  <= 0;
      hold_q <= 1;
    end else begin
      if (pwr_fail && en_n != 4'hF) tmo_q <= (tmo_q < WPT_CYC + 2) ? tmo_q + 1 : tmo_q;
      else                          tmo_q <= 0;
      if (pwr_fail)                 hold_q <= 0;
      else if (hold_q < REC_CYC + 1) hold_q <= hold_q + 1;
    end
  end

  // R2
  idle_ce_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (en_n == 4'hF));

  // R3
  one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~en_n));

  // R10
  wp_forced_chk: assert property (@(posedge clk) disable iff (rst)
    wp |-> (en_n == 4'hF));

  // R7
  no_new_access_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_fail && wp) |=> (wp && en_n == 4'hF));

  // R6
  drain_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_q <= WPT_CYC + 1);

  // R8
  recovery_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_q != 0 && hold_q <= REC_CYC) |-> (wp && en_n == 4'hF));
endmodule

bind pf_ce_gate pf_ce_gate_chk #(
  .WPT_CYC (WPT_CYC),
  .REC_CYC (REC_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n),
  .pwr_fail (pwr_fail),
  .en_n     (en_n),
  .wp       (wp)
);

// File: tb/pf_ce_gate_tb.sv
module pf_ce_gate_tb;
  localparam int WPT = 4;
  localparam int REC = 8;
  localparam logic [3:0] OFF = 4'hF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce_n = 1'b1;
  logic       sel_a = 1'b0;
  logic       sel_b = 1'b0;
  logic       pwr_fail = 1'b0;
  logic [3:0] en_n;
  logic       wp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pf_ce_gate #(.WPT_CYC(WPT), .REC_CYC(REC)) u_dut (
    .clk (clk), .rst (rst), .ce_n (ce_n), .sel_a (sel_a), .sel_b (sel_b),
    .pwr_fail (pwr_fail), .en_n (en_n), .wp (wp)
  );

  function automatic logic [3:0] lane(input int s);
    return ~(4'b0001 << s);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic ce, input int s, input logic pf);
    ce_n = ce;
    {sel_b, sel_a} = 2'(s);
    pwr_fail = pf;
  endtask

  task automatic check(input string tag, input logic [3:0] exp_en, input logic exp_wp);
    n_chk++;
    if (en_n !== exp_en || wp !== exp_wp) begin
      n_bad++;
      $display("FAIL %s: en_n=%b wp=%b expected en_n=%b wp=%b", tag, en_n, wp, exp_en, exp_wp);
    end
  endtask

  // pwr_fail low from now: REC forced cycles, then decoding of (ce_n low, sel s)
  task automatic recover(input int s, input string tag);
    drive(1'b0, s, 1'b0);
    for (int k = 0; k < REC; k++) begin
      tick();
      check({tag, " R8 hold"}, OFF, 1'b1);
    end
    tick();
    check({tag, " R8 resume"}, lane(s), 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(1'b0, 0, 1'b0);
    repeat (3) tick();
    check("R9 reset", OFF, 1'b1);
    rst = 1'b0;
    for (int k = 1; k < REC; k++) begin
      tick();
      check("R9 hold after reset", OFF, 1'b1);
    end
    tick();
    check("R9 R1 first decode", lane(0), 1'b0);
  endtask

  task automatic t_decode();
    for (int s = 0; s < 4; s++) begin
      drive(1'b0, s, 1'b0);
      tick();
      check("R1 R3 R10 decode", lane(s), 1'b0);
    end
    for (int s = 0; s < 4; s++) begin
      drive(1'b1, s, 1'b0);
      tick();
      check("R2 ce high", OFF, 1'b0);
    end
  endtask

  task automatic t_pf_idle();
    drive(1'b1, 1, 1'b1);
    tick();
    check("R4 idle protect", OFF, 1'b1);
    drive(1'b0, 2, 1'b1);
    repeat (3) begin
      tick();
      check("R7 new access blocked", OFF, 1'b1);
    end
    recover(1, "idle");
  endtask

  task automatic t_drain_end();
    drive(1'b0, 3, 1'b0);
    tick();
    check("R1 pre-drain", lane(3), 1'b0);
    drive(1'b0, 3, 1'b1);
    tick();
    check("R5 R10 detect during access", lane(3), 1'b0);
    drive(1'b0, 0, 1'b1);
    tick();
    check("R5 latched select", lane(3), 1'b0);
    drive(1'b1, 0, 1'b1);
    tick();
    check("R5 access ended", OFF, 1'b1);
    drive(1'b0, 0, 1'b1);
    tick();
    check("R7 after drain", OFF, 1'b1);
    recover(3, "drain");
  endtask

  task automatic t_timeout();
    drive(1'b0, 1, 1'b0);
    tick();
    check("R1 pre-timeout", lane(1), 1'b0);
    drive(1'b0, 1, 1'b1);
    tick();
    check("R6 detect edge", lane(1), 1'b0);
    for (int k = 1; k < WPT; k++) begin
      tick();
      check("R6 within window", lane(1), 1'b0);
    end
    tick();
    check("R6 timeout forced", OFF, 1'b1);
    tick();
    check("R7 after timeout", OFF, 1'b1);
    recover(2, "timeout");
  endtask

  task automatic t_clear_in_drain();
    drive(1'b0, 2, 1'b1);
    tick();
    check("R5 detect", lane(2), 1'b0);
    recover(2, "clear in drain");
  endtask

  task automatic t_pf_in_hold();
    drive(1'b1, 0, 1'b1);
    tick();
    check("R4 protect", OFF, 1'b1);
    drive(1'b0, 0, 1'b0);
    repeat (3) begin
      tick();
      check("R8 partial hold", OFF, 1'b1);
    end
    drive(1'b0, 0, 1'b1);
    tick();
    check("R8 re-fail in hold", OFF, 1'b1);
    recover(0, "restart");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_pf_idle();
    t_drain_end();
    t_timeout();
    t_clear_in_drain();
    t_pf_in_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule